// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point register storage of a processor core: one physical array of 64 entries, each 32 bits wide. It performs no arithmetic and keeps no flags; it only stores bit patterns and presents them through several overlapping views of the same storage.

A single view reads and writes one entry. A double view reads and writes two neighbouring entries as one 64-bit value, with the lower-numbered entry in the upper half. A vector view and a matrix view each take a short index, mask it and scale it, and return the first entry of the selected group. Writes take effect at the clock edge. Reads are combinational from the index inputs.

Top module: `fprf_top`

## Requirements
- R1: While reset is low and after its release, every entry reads as zero in every view until it is written.
- R2: A single write at index i with its enable high stores the 32-bit data into entry i at the clock edge. The single read port returns entry i combinationally.
- R3: The double read at index i returns entry i in bits 63:32 and entry i+1 in bits 31:0.
- R4: A double write at index i stores bits 63:32 into entry i and bits 31:0 into entry i+1, both at the same clock edge.
- R5: A double access at index 63 uses entry 0 as its second entry, for both reads and writes.
- R6: The vector read returns entry (idx mod 16) * 4. Index bits 5:4 have no effect.
- R7: The matrix read returns entry (idx mod 4) * 16. Index bits 5:2 have no effect.
- R8: If a single write and a double write hit the same entry in one cycle, that entry takes the double write data. A single write to any other entry still completes.
- R9: When both write enables are low, no entry changes, whatever the data and index inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset that clears all entries |
| soloWrEn | input | 1 | Single-view write enable |
| soloWrIdx | input | 6 | Single-view write index |
| soloWrData | input | 32 | Single-view write data |
| duoWrEn | input | 1 | Double-view write enable |
| duoWrIdx | input | 6 | Double-view write index (first entry) |
| duoWrData | input | 64 | Double-view write data, upper half to the first entry |
| soloRdIdx | input | 6 | Single-view read index |
| soloRdData | output | 32 | Single-view read data |
| duoRdIdx | input | 6 | Double-view read index |
| duoRdData | output | 64 | Double-view read data |
| vecIdx | input | 6 | Vector-view index, masked to 4 bits |
| vecData | output | 32 | Base entry of the selected vector |
| mtxIdx | input | 6 | Matrix-view index, masked to 2 bits |
| mtxData | output | 32 | Base entry of the selected matrix |

## Verification
The array is first filled with values that are distinct and depend on the index. This way any wrong address, swapped half or wrong scale shows up as a wrong value rather than a match by chance. The double view is tried at an interior index, at index 62 and at index 63. This separates a correct wrap from an out-of-range read and a correct half order from a swapped one. The vector and matrix indices sweep all 64 codes, so a missing mask on the upper bits or a wrong scale factor shows up. The overlap cases put the single write on the first entry of the pair, on the second entry, and on the wrapped entry 0, so the priority is checked on each path.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int ENTRIES  = 64;
  localparam int DATA_W   = 32;
  localparam int VEC_LEN  = 4;
  localparam int MTX_LEN  = 16;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int VSEL_W   = $clog2(ENTRIES / VEC_LEN);
  localparam int MSEL_W   = $clog2(ENTRIES / MTX_LEN);
  localparam int VSHIFT   = $clog2(VEC_LEN);
  localparam int MSHIFT   = $clog2(MTX_LEN);

  typedef logic [IDX_W-1:0] idx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic soloWe;
    idx_t soloAddr;
    logic duoWe;
    idx_t duoHiAddr;
    idx_t duoLoAddr;
    idx_t soloRdAddr;
    idx_t duoRdHi;
    idx_t duoRdLo;
    idx_t vecAddr;
    idx_t mtxAddr;
  } strobes_t;
endpackage

// File: rtl/fprf_ctrl.sv
module fprf_ctrl
  import fprf_pkg::*;
(
  input  logic     rstN,
  input  logic     soloWrEn,
  input  idx_t     soloWrIdx,
  input  logic     duoWrEn,
  input  idx_t     duoWrIdx,
  input  idx_t     soloRdIdx,
  input  idx_t     duoRdIdx,
  input  idx_t     vecIdx,
  input  idx_t     mtxIdx,
  output strobes_t strobes
);
  idx_t duoWrNext;
  logic overlap;

  // second entry of a pair wraps modulo the array size
  assign duoWrNext = duoWrIdx + idx_t'(1);
  assign overlap   = duoWrEn && (soloWrIdx == duoWrIdx || soloWrIdx == duoWrNext);

  always_comb begin
    strobes            = '0;
    strobes.soloWe     = rstN && soloWrEn && !overlap;
    strobes.soloAddr   = soloWrIdx;
    strobes.duoWe      = rstN && duoWrEn;
    strobes.duoHiAddr  = duoWrIdx;
    strobes.duoLoAddr  = duoWrNext;
    strobes.soloRdAddr = soloRdIdx;
    strobes.duoRdHi    = duoRdIdx;
    strobes.duoRdLo    = duoRdIdx + idx_t'(1);
    strobes.vecAddr    = idx_t'({vecIdx[VSEL_W-1:0], {VSHIFT{1'b0}}});
    strobes.mtxAddr    = idx_t'({mtxIdx[MSEL_W-1:0], {MSHIFT{1'b0}}});
  end
endmodule

// File: rtl/fprf_datapath.sv
module fprf_datapath
  import fprf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [DATA_W-1:0]   soloWrData,
  input  logic [2*DATA_W-1:0] duoWrData,
  output logic [DATA_W-1:0]   soloRdData,
  output logic [2*DATA_W-1:0] duoRdData,
  output logic [DATA_W-1:0]   vecData,
  output logic [DATA_W-1:0]   mtxData
);
  logic [DATA_W-1:0] bank [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) bank[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strobes.duoWe && strobes.duoHiAddr == idx_t'(e))
          bank[e] <= duoWrData[2*DATA_W-1:DATA_W];
        else if (strobes.duoWe && strobes.duoLoAddr == idx_t'(e))
          bank[e] <= duoWrData[DATA_W-1:0];
        else if (strobes.soloWe && strobes.soloAddr == idx_t'(e))
          bank[e] <= soloWrData;
      end
    end
  end

  assign soloRdData = bank[strobes.soloRdAddr];
  assign duoRdData  = {bank[strobes.duoRdHi], bank[strobes.duoRdLo]};
  assign vecData    = bank[strobes.vecAddr];
  assign mtxData    = bank[strobes.mtxAddr];

  // R4 R8
  duo_hi_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.duoWe |=> bank[$past(strobes.duoHiAddr)] == $past(duoWrData[2*DATA_W-1:DATA_W]));
  // R4 R5 R8
  duo_lo_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.duoWe |=> bank[$past(strobes.duoLoAddr)] == $past(duoWrData[DATA_W-1:0]));
  // R2
  solo_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.soloWe |=> bank[$past(strobes.soloAddr)] == $past(soloWrData));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.soloWe && !strobes.duoWe) |=> bank[$past(strobes.soloAddr)] == $past(bank[strobes.soloAddr]));
endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                soloWrEn,
  input  logic [IDX_W-1:0]    soloWrIdx,
  input  logic [DATA_W-1:0]   soloWrData,
  input  logic                duoWrEn,
  input  logic [IDX_W-1:0]    duoWrIdx,
  input  logic [2*DATA_W-1:0] duoWrData,
  input  logic [IDX_W-1:0]    soloRdIdx,
  output logic [DATA_W-1:0]   soloRdData,
  input  logic [IDX_W-1:0]    duoRdIdx,
  output logic [2*DATA_W-1:0] duoRdData,
  input  logic [IDX_W-1:0]    vecIdx,
  output logic [DATA_W-1:0]   vecData,
  input  logic [IDX_W-1:0]    mtxIdx,
  output logic [DATA_W-1:0]   mtxData
);
  strobes_t strobes;

  fprf_ctrl ctrl (
    .rstN(rstN), .soloWrEn(soloWrEn), .soloWrIdx(soloWrIdx),
    .duoWrEn(duoWrEn), .duoWrIdx(duoWrIdx), .soloRdIdx(soloRdIdx),
    .duoRdIdx(duoRdIdx), .vecIdx(vecIdx), .mtxIdx(mtxIdx), .strobes(strobes)
  );

  fprf_datapath dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .soloWrData(soloWrData),
    .duoWrData(duoWrData), .soloRdData(soloRdData), .duoRdData(duoRdData),
    .vecData(vecData), .mtxData(mtxData)
  );

  // R3
  duo_hi_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soloRdIdx == duoRdIdx) |-> duoRdData[2*DATA_W-1:DATA_W] == soloRdData);
  // R3 R5
  duo_lo_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soloRdIdx == duoRdIdx + IDX_W'(1)) |-> duoRdData[DATA_W-1:0] == soloRdData);
  // R6
  vec_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soloRdIdx == IDX_W'({vecIdx[VSEL_W-1:0], {VSHIFT{1'b0}}})) |-> vecData == soloRdData);
  // R7
  mtx_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soloRdIdx == IDX_W'({mtxIdx[MSEL_W-1:0], {MSHIFT{1'b0}}})) |-> mtxData == soloRdData);
endmodule

// File: tb/fprf_top_test.sv
module fprf_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        soloWrEn = 1'b0;
  logic [5:0]  soloWrIdx = '0;
  logic [31:0] soloWrData = '0;
  logic        duoWrEn = 1'b0;
  logic [5:0]  duoWrIdx = '0;
  logic [63:0] duoWrData = '0;
  logic [5:0]  soloRdIdx = '0;
  logic [31:0] soloRdData;
  logic [5:0]  duoRdIdx = '0;
  logic [63:0] duoRdData;
  logic [5:0]  vecIdx = '0;
  logic [31:0] vecData;
  logic [5:0]  mtxIdx = '0;
  logic [31:0] mtxData;

  logic [31:0] refMem [64];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fprf_top uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeSolo(int i, logic [31:0] d);
    soloWrEn = 1'b1; soloWrIdx = 6'(i); soloWrData = d;
    tick();
    soloWrEn = 1'b0;
    refMem[i] = d;
  endtask

  task automatic fillAll();
    for (int i = 0; i < 64; i++) writeSolo(i, 32'hA500_0000 | (32'(i) * 32'h0001_0203));
  endtask

  task automatic testReset();
    for (int i = 0; i < 64; i++) begin
      soloRdIdx = 6'(i); #1;
      chk("R1 solo", 64'(soloRdData), 64'h0);
    end
    duoRdIdx = 6'd63; vecIdx = 6'd5; mtxIdx = 6'd3; #1;
    chk("R1 duo", duoRdData, 64'h0);
    chk("R1 vec", 64'(vecData), 64'h0);
    chk("R1 mtx", 64'(mtxData), 64'h0);
  endtask

  task automatic testSolo();
    writeSolo(7, 32'h1234_5678);
    soloRdIdx = 6'd7; #1;
    chk("R2 solo write", 64'(soloRdData), 64'h1234_5678);
    fillAll();
    for (int i = 0; i < 64; i++) begin
      soloRdIdx = 6'(i); #1;
      chk("R2 solo read", 64'(soloRdData), 64'(refMem[i]));
    end
  endtask

  task automatic testDuoRead();
    for (int i = 0; i < 64; i++) begin
      duoRdIdx = 6'(i); #1;
      chk("R3 R5 duo read", duoRdData, {refMem[i], refMem[(i + 1) % 64]});
    end
  endtask

  task automatic testDuoWrite();
    duoWrEn = 1'b1; duoWrIdx = 6'd20; duoWrData = 64'hDEAD_BEEF_CAFE_F00D;
    tick();
    duoWrEn = 1'b0;
    refMem[20] = 32'hDEAD_BEEF; refMem[21] = 32'hCAFE_F00D;
    soloRdIdx = 6'd20; #1; chk("R4 hi entry", 64'(soloRdData), 64'(refMem[20]));
    soloRdIdx = 6'd21; #1; chk("R4 lo entry", 64'(soloRdData), 64'(refMem[21]));
    soloRdIdx = 6'd22; #1; chk("R4 neighbour", 64'(soloRdData), 64'(refMem[22]));
  endtask

  task automatic testWrap();
    duoWrEn = 1'b1; duoWrIdx = 6'd63; duoWrData = 64'h6363_6363_0000_0F0F;
    tick();
    duoWrEn = 1'b0;
    refMem[63] = 32'h6363_6363; refMem[0] = 32'h0000_0F0F;
    soloRdIdx = 6'd0; #1; chk("R5 wrap write", 64'(soloRdData), 64'h0000_0F0F);
    soloRdIdx = 6'd63; #1; chk("R5 wrap hi", 64'(soloRdData), 64'h6363_6363);
    duoRdIdx = 6'd63; #1; chk("R5 wrap read", duoRdData, 64'h6363_6363_0000_0F0F);
  endtask

  task automatic testVec();
    for (int i = 0; i < 64; i++) begin
      vecIdx = 6'(i); #1;
      chk("R6 vec", 64'(vecData), 64'(refMem[(i % 16) * 4]));
    end
  endtask

  task automatic testMtx();
    for (int i = 0; i < 64; i++) begin
      mtxIdx = 6'(i); #1;
      chk("R7 mtx", 64'(mtxData), 64'(refMem[(i % 4) * 16]));
    end
  endtask

  task automatic collide(int s, int p, logic [63:0] dd, logic [31:0] sd);
    soloWrEn = 1'b1; soloWrIdx = 6'(s); soloWrData = sd;
    duoWrEn = 1'b1; duoWrIdx = 6'(p); duoWrData = dd;
    tick();
    soloWrEn = 1'b0; duoWrEn = 1'b0;
    refMem[p] = dd[63:32]; refMem[(p + 1) % 64] = dd[31:0];
    if (s != p && s != (p + 1) % 64) refMem[s] = sd;
    for (int i = 0; i < 64; i++) begin
      soloRdIdx = 6'(i); #1;
      if (i == s || i == p || i == (p + 1) % 64)
        chk("R8 collide", 64'(soloRdData), 64'(refMem[i]));
    end
  endtask

  task automatic testCollide();
    collide(10, 10, 64'h1111_1111_2222_2222, 32'h9999_9999);
    collide(31, 30, 64'h3333_3333_4444_4444, 32'h8888_8888);
    collide(0, 63, 64'h5555_5555_6666_6666, 32'h7777_7777);
    collide(40, 44, 64'hAAAA_AAAA_BBBB_BBBB, 32'hCCCC_CCCC);
  endtask

  task automatic testIdle();
    soloWrIdx = 6'd3; soloWrData = 32'hFFFF_FFFF;
    duoWrIdx = 6'd5; duoWrData = '1;
    tick(); tick();
    soloWrData = 32'h0; duoWrData = '0;
    for (int i = 0; i < 64; i++) begin
      soloRdIdx = 6'(i); #1;
      chk("R9 idle", 64'(soloRdData), 64'(refMem[i]));
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refMem[i] = '0;
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testSolo();
    testDuoRead();
    testDuoWrite();
    testWrap();
    testVec();
    testMtx();
    testCollide();
    testIdle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule